// File: doc/BRIEF.md
# High-Side Switch and Bootstrap Recharge Deadtime Sequencer

This synchronous controller decides, cycle by cycle, whether a floating high-side power switch or a bootstrap-recharge switch may conduct. It takes an active-low drive command and an active-high enable. It also takes two digital supply-health flags, one for the logic supply and one for the floating supply. Each flag is produced elsewhere, with hysteresis already applied. The controller drives one gate command for each switch. The two switches are never on together. Each handover passes through a deadtime interval, and the two directions have their own lengths.

Both deadtimes are given in nanoseconds and turned into clock cycles from a clock-frequency parameter. Handing over from the high side to recharge is slow, nominally 11 µs. Handing over from recharge to the high side is fast, nominally 0.8 µs. Every input passes through a two-flop synchroniser. The command and the enable also pass a glitch filter that ignores pulses shorter than a set number of cycles. The two supply flags act differently. A logic-supply fault turns recharge on. A floating-supply fault only blocks the high side, so both switches stay off while the command still asks for drive.

Top module: `gd_seq_top`

## Requirements
- R1: `hs_gate_o` and `rech_gate_o` are never high in the same cycle.
- R2: `hs_gate_o` goes high only while `drv_cmd_n` is low, `drv_en` is high and both `logic_ok` and `float_ok` are high, once the input latency has passed.
- R3: While `drv_en` is low, `hs_gate_o` is low whatever `drv_cmd_n` is. Recharge then turns on after the recharge deadtime.
- R4: After `hs_gate_o` falls, `rech_gate_o` stays low for at least the recharge deadtime. That is ceil(CLK_HZ·RECH_DEAD_NS/1e9) cycles, 110 with the defaults (10 MHz, 11000 ns).
- R5: After `rech_gate_o` falls, `hs_gate_o` stays low for at least the high-side deadtime. That is ceil(CLK_HZ·HS_DEAD_NS/1e9) cycles, 8 with the defaults (800 ns).
- R6: While `logic_ok` is low, `hs_gate_o` is low and `rech_gate_o` is high after the recharge deadtime, even when the command asks for drive.
- R7: When `float_ok` is low and the command asks for drive (`drv_cmd_n` low, `drv_en` high), both outputs stay low. When the command releases drive, recharge turns on.
- R8: During reset and afterwards, both outputs are low. Recharge may turn on, and the high side may start, only once the recharge deadtime has run from reset.
- R9: If a request is withdrawn while its deadtime is still running, the switch that was on before turns back on without waiting out a deadtime. The other switch never pulses.
- R10: A pulse on `drv_cmd_n` or `drv_en` shorter than FILT_LEN cycles (default 3) has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_cmd_n | input | 1 | Drive command, low requests the high side on |
| drv_en | input | 1 | Enable; low forces the high side off |
| logic_ok | input | 1 | Logic-supply health flag, high when healthy |
| float_ok | input | 1 | Floating-supply health flag, high when healthy |
| hs_gate_o | output | 1 | High-side switch gate command |
| rech_gate_o | output | 1 | Recharge switch gate command |

## Verification
The embedded properties check four things on every cycle: that the two gate commands never overlap, that each rising edge follows at least its own deadtime of continuous off-time on the opposite switch, that a low enable or either supply fault drops the high side on the next cycle, and that the glitch filter holds its output while its input agrees. Other behaviour can only be shown by the directed scenarios, by watching the outputs over long windows. These are the exact lengths of the deadtime gaps, the late recharge turn-on under a logic-supply fault, the idle state with both outputs off under a floating-supply fault, aborted handovers that return to the earlier switch, and short pulses that are absorbed.

// File: rtl/gd_pkg.sv
package gd_pkg;

  typedef enum logic [1:0] {
    ST_HS_ON        = 2'd0,
    ST_DEAD_TO_RECH = 2'd1,
    ST_RECH_ON      = 2'd2,
    ST_DEAD_TO_HS   = 2'd3
  } seq_state_e;

  // Rounds a duration in nanoseconds up to whole clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                               input int unsigned dur_ns);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(dur_ns);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gd_glitch_filt.sv
module gd_glitch_filt #(
  parameter int unsigned LEN     = 3,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          differs;
  assign differs = (din != dout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= RST_VAL;
      run_q <= '0;
    end else if (!differs) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R10: an input that agrees with the output cannot move it
  p_filt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(dout));
endmodule

// File: rtl/gd_seq_fsm.sv
module gd_seq_fsm #(
  parameter int unsigned DT_OFF = 110,
  parameter int unsigned DT_ON  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic en,
  input  logic logic_ok,
  input  logic float_ok,
  output logic hs_q,
  output logic rech_q
);
  import gd_pkg::*;

  localparam int unsigned DT_MAX = (DT_OFF > DT_ON) ? DT_OFF : DT_ON;
  localparam int unsigned CW     = $clog2(DT_MAX + 1);
  localparam logic [CW-1:0] DT_OFF_C = CW'(DT_OFF);
  localparam logic [CW-1:0] DT_ON_C  = CW'(DT_ON);

  seq_state_e st_q, st_nxt;
  logic [CW-1:0] cnt_q;
  logic boot_q;

  // named internal events
  logic drive_asked, hs_req, rech_req, cnt_done, ld_off, ld_on;
  assign drive_asked = en & ~cmd_n;
  assign hs_req      = drive_asked & logic_ok & float_ok;
  assign rech_req    = ~logic_ok | ~drive_asked;
  assign cnt_done    = (cnt_q == '0);

  always_comb begin
    st_nxt = st_q;
    ld_off = 1'b0;
    ld_on  = 1'b0;
    unique case (st_q)
      ST_HS_ON: if (!hs_req) begin
        st_nxt = ST_DEAD_TO_RECH;
        ld_off = 1'b1;
      end
      ST_DEAD_TO_RECH: begin
        if (hs_req && (cnt_done || !boot_q)) st_nxt = ST_HS_ON;
        else if (rech_req && cnt_done)       st_nxt = ST_RECH_ON;
      end
      ST_RECH_ON: if (!rech_req) begin
        st_nxt = ST_DEAD_TO_HS;
        ld_on  = 1'b1;
      end
      ST_DEAD_TO_HS: begin
        if (rech_req)                   st_nxt = ST_RECH_ON;
        else if (hs_req && cnt_done)    st_nxt = ST_HS_ON;
      end
      default: st_nxt = ST_DEAD_TO_RECH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_DEAD_TO_RECH;
      cnt_q  <= DT_OFF_C;
      boot_q <= 1'b1;
      hs_q   <= 1'b0;
      rech_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      hs_q   <= (st_nxt == ST_HS_ON);
      rech_q <= (st_nxt == ST_RECH_ON);
      if (cnt_done) boot_q <= 1'b0;
      if (ld_off)          cnt_q <= DT_OFF_C;
      else if (ld_on)      cnt_q <= DT_ON_C;
      else if (!cnt_done)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // Off-time counters for the checks, independent of the sequencer counter.
  logic [CW-1:0] hs_off_run, rech_off_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_off_run   <= '0;
      rech_off_run <= '0;
    end else begin
      if (hs_q)                     hs_off_run <= '0;
      else if (hs_off_run < DT_OFF_C) hs_off_run <= hs_off_run + 1'b1;
      if (rech_q)                     rech_off_run <= '0;
      else if (rech_off_run < DT_ON_C) rech_off_run <= rech_off_run + 1'b1;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && rech_q));
  p_en_low_blocks_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hs_q);
  p_rech_deadtime_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rech_q) |-> (hs_off_run >= DT_OFF_C));
  p_hs_deadtime_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> (rech_off_run >= DT_ON_C));
  p_logic_fault_hs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !logic_ok |=> !hs_q);
  p_float_fault_hs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !float_ok |=> !hs_q);
endmodule

// File: rtl/gd_seq_top.sv
module gd_seq_top #(
  parameter int unsigned CLK_HZ       = 10_000_000,
  parameter int unsigned RECH_DEAD_NS = 11_000,
  parameter int unsigned HS_DEAD_NS   = 800,
  parameter int unsigned FILT_LEN     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_cmd_n,
  input  logic drv_en,
  input  logic logic_ok,
  input  logic float_ok,
  output logic hs_gate_o,
  output logic rech_gate_o
);
  localparam int unsigned DT_OFF = gd_pkg::ns_to_cycles(CLK_HZ, RECH_DEAD_NS);
  localparam int unsigned DT_ON  = gd_pkg::ns_to_cycles(CLK_HZ, HS_DEAD_NS);
  localparam int unsigned NFILT  = 2;
  // bit order: {float_ok, logic_ok, drv_en, drv_cmd_n}
  localparam logic [3:0] SYNC_RST = 4'b0001;

  logic [3:0] raw_in, sync_out;
  logic [NFILT-1:0] filt_out;
  assign raw_in = {float_ok, logic_ok, drv_en, drv_cmd_n};

  gd_sync #(.W(4), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    gd_glitch_filt #(.LEN(FILT_LEN), .RST_VAL(SYNC_RST[g])) u_filt (
      .clk(clk), .rst_n(rst_n), .din(sync_out[g]), .dout(filt_out[g])
    );
  end

  gd_seq_fsm #(.DT_OFF(DT_OFF), .DT_ON(DT_ON)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_n(filt_out[0]), .en(filt_out[1]),
    .logic_ok(sync_out[2]), .float_ok(sync_out[3]),
    .hs_q(hs_gate_o), .rech_q(rech_gate_o)
  );
endmodule

// File: tb/gd_seq_top_tb_top.sv
module gd_seq_top_tb_top;
  localparam int CLK_NS = 100;               // 10 MHz
  localparam int DT_OFF = 11000 / CLK_NS;    // 110 cycles
  localparam int DT_ON  = 800 / CLK_NS;      // 8 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_cmd_n = 1'b1, drv_en = 1'b1, logic_ok = 1'b1, float_ok = 1'b1;
  logic hs_gate_o, rech_gate_o;
  int checks = 0, fails = 0, overlap_seen = 0;

  always #(CLK_NS/2) clk = ~clk;

  gd_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .drv_cmd_n(drv_cmd_n), .drv_en(drv_en),
    .logic_ok(logic_ok), .float_ok(float_ok),
    .hs_gate_o(hs_gate_o), .rech_gate_o(rech_gate_o)
  );

  always @(negedge clk) if (rst_n && hs_gate_o && rech_gate_o) overlap_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(input bit sel_hs, input bit val, input int maxc, output int n);
    n = 0;
    while (((sel_hs ? hs_gate_o : rech_gate_o) != val) && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic watch(input int n, output int hs_hi, output int rech_hi);
    hs_hi = 0; rech_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hs_gate_o) hs_hi++;
      if (rech_gate_o) rech_hi++;
    end
  endtask

  // request drive and measure the recharge->high-side gap
  task automatic go_hs(input string req);
    int n;
    drv_cmd_n = 1'b0;
    wait_for(1'b0, 1'b0, 40, n);
    wait_for(1'b1, 1'b1, DT_ON + 40, n);
    chk(n >= DT_ON && n <= DT_ON + 2, req, n, DT_ON + 1);
  endtask

  task automatic go_rech(input string req);
    int n;
    drv_cmd_n = 1'b1;
    wait_for(1'b1, 1'b0, 40, n);
    wait_for(1'b0, 1'b1, DT_OFF + 40, n);
    chk(n >= DT_OFF && n <= DT_OFF + 2, req, n, DT_OFF + 1);
  endtask

  task automatic t_reset;
    int n;
    cyc(3);
    chk(!hs_gate_o && !rech_gate_o, "R8 outputs low in reset", {hs_gate_o, rech_gate_o}, 0);
    rst_n = 1'b1;
    wait_for(1'b0, 1'b1, DT_OFF + 40, n);
    chk(n >= DT_OFF && n <= DT_OFF + 3, "R8 recharge after reset deadtime", n, DT_OFF + 1);
    chk(!hs_gate_o, "R8 high side off after reset", hs_gate_o, 0);
  endtask

  task automatic t_switching;
    go_hs("R5 recharge-to-high-side gap");
    chk(hs_gate_o, "R2 high side on when commanded", hs_gate_o, 1);
    go_rech("R4 high-side-to-recharge gap");
  endtask

  task automatic t_enable;
    int n;
    go_hs("R5 gap before enable test");
    drv_en = 1'b0;
    wait_for(1'b1, 1'b0, 30, n);
    chk(n < 30, "R3 enable low drops high side", n, 8);
    wait_for(1'b0, 1'b1, DT_OFF + 40, n);
    chk(rech_gate_o, "R3 recharge on with enable low", rech_gate_o, 1);
    drv_en = 1'b1;
    wait_for(1'b1, 1'b1, DT_ON + 40, n);
    chk(hs_gate_o, "R2 high side returns on enable", hs_gate_o, 1);
  endtask

  task automatic t_float;
    int n, h, r;
    float_ok = 1'b0;
    wait_for(1'b1, 1'b0, 30, n);
    chk(!hs_gate_o, "R7 float fault drops high side", hs_gate_o, 0);
    watch(2 * DT_OFF, h, r);
    chk(h == 0 && r == 0, "R7 both off while commanded", r, 0);
    drv_cmd_n = 1'b1;
    wait_for(1'b0, 1'b1, 40, n);
    chk(rech_gate_o, "R7 recharge on when released", rech_gate_o, 1);
    float_ok = 1'b1;
    cyc(10);
  endtask

  task automatic t_logic;
    int n;
    go_hs("R5 gap before logic fault");
    logic_ok = 1'b0;
    wait_for(1'b1, 1'b0, 30, n);
    chk(n < 30, "R6 logic fault drops high side", n, 4);
    wait_for(1'b0, 1'b1, DT_OFF + 40, n);
    chk(n >= DT_OFF && rech_gate_o, "R6 recharge on under logic fault", n, DT_OFF + 1);
    logic_ok = 1'b1;
    wait_for(1'b1, 1'b1, DT_ON + 40, n);
    chk(hs_gate_o, "R2 high side after logic recovers", hs_gate_o, 1);
  endtask

  task automatic t_abort;
    int h, r, n;
    drv_cmd_n = 1'b1; cyc(20); drv_cmd_n = 1'b0;
    watch(60, h, r);
    chk(r == 0 && hs_gate_o, "R9 abort back to high side", r, 0);
    go_rech("R4 gap before second abort");
    drv_cmd_n = 1'b0; cyc(5); drv_cmd_n = 1'b1;
    watch(40, h, r);
    chk(h == 0 && rech_gate_o, "R9 abort back to recharge", h, 0);
    wait_for(1'b0, 1'b1, 10, n);
  endtask

  task automatic t_glitch;
    int h, r;
    drv_cmd_n = 1'b0; cyc(1); drv_cmd_n = 1'b1;
    watch(30, h, r);
    chk(h == 0 && r == 30, "R10 command glitch ignored", r, 30);
    go_hs("R5 gap before enable glitch");
    drv_en = 1'b0; cyc(2); drv_en = 1'b1;
    watch(30, h, r);
    chk(h == 30 && r == 0, "R10 enable glitch ignored", h, 30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_switching();
    t_enable();
    t_float();
    t_logic();
    t_abort();
    t_glitch();
    chk(overlap_seen == 0, "R1 no overlap", overlap_seen, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule